// File: doc/BRIEF.md
# Privilege-Gated Clock and Voltage Scaling Register Block

This block is a small register file inside a hardware root of trust. It holds the frequency code and voltage code of each scaled power domain, and it drives those codes to the clock generator and the regulator. Any agent on the register bus can reach the block, including untrusted cores. A sidecar privilege flag marks each access. Only the trusted controller asserts that flag.

The scaling codes sit in one contiguous, inclusive address window. A write into that window changes state only when two conditions hold: the requester is privileged, and the lock register is clear. The lock register itself also takes writes only from privileged requesters, so no unprivileged access can set it, clear it or bypass it. A write that breaks these rules changes nothing. It raises a one-cycle violation pulse and a sticky error flag, which only a privileged requester can clear. Scratch registers and reads are open to every requester.

Top module: `scal_ctrl_regs`

## Requirements
- R1: After reset, lock_o is 1, err_o and viol_o are 0, every frequency code is FREQ_RST (0x10), every voltage code is VOLT_RST (0x30), the scratch registers read 0 and rdata_o is 0.
- R2: The scaling window runs from address 4 to address 7 inclusive. Domain d has its frequency code at 4+2d and its voltage code at 5+2d. A privileged write into the window while the lock is clear changes freq_o or volt_o at the clock edge that samples the write, and never before that edge. Domain d occupies bits [8d+7:8d] of each output.
- R3: While lock_o is 1, no write into the scaling window changes freq_o or volt_o, whatever the privilege.
- R4: The lock is bit 0 at address 0, and 1 means locked. A privileged write loads bit 0. An unprivileged write to address 0, or into the window, leaves the lock and the scaling codes unchanged.
- R5: A blocked write raises viol_o for exactly the one cycle after the edge that sampled it, and it sets err_o at that same edge. Three kinds of write are blocked: an unprivileged write to address 0 or 1, an unprivileged write into the window, and any write into the window while locked. No other write is blocked, including a write to an unmapped address.
- R6: err_o reads back as bit 0 at address 1. It stays set until a privileged write to address 1 with bit 0 set. A privileged write there with bit 0 clear leaves err_o unchanged.
- R7: A read updates rdata_o at the sampling edge with the value the register held before that edge, for any privilege. rdata_o holds its value while re_i is low. Reads of addresses 2, 3 and 10 to 15 return 0.
- R8: Addresses 8 and 9 are scratch registers. Any requester can write them, with or without the lock, and they never raise a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W (4) | Register word address |
| wdata_i | input | DATA_W (8) | Write data |
| we_i | input | 1 | Write enable |
| re_i | input | 1 | Read enable |
| priv_i | input | 1 | Requester is the trusted controller |
| rdata_o | output | DATA_W (8) | Registered read data |
| freq_o | output | NUM_DOM*DATA_W (16) | Frequency codes, one byte per domain |
| volt_o | output | NUM_DOM*DATA_W (16) | Voltage codes, one byte per domain |
| lock_o | output | 1 | Scaling window locked |
| viol_o | output | 1 | One-cycle blocked-write pulse |
| err_o | output | 1 | Sticky access-violation flag |

## Verification
The assertions assume that we_i, re_i, priv_i, addr_i and wdata_i are stable around the sampling edge. The error-clear property also assumes that priv_i honestly reflects the requester. All bus inputs are driven at the falling edge and held for one full cycle, so each access is sampled exactly once. The sweep crosses every address with both lock states and both privilege values. After each write it reads back the whole map, so an ignored write can be seen at the ports.

// File: rtl/scal_pkg.sv
package scal_pkg;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_LOCK = 3'd1,
    SEL_STAT = 3'd2,
    SEL_WIN  = 3'd3,
    SEL_SCR  = 3'd4
  } sel_e;

endpackage

// File: rtl/scal_access_gate.sv
module scal_access_gate
  import scal_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned LOCK_ADDR = 0,
  parameter int unsigned STAT_ADDR = 1,
  parameter int unsigned WIN_START = 4,
  parameter int unsigned WIN_LEN   = 4,
  parameter int unsigned SCR_BASE  = 8,
  parameter int unsigned NUM_SCR   = 2,
  localparam int unsigned WIN_IW   = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1,
  localparam int unsigned SCR_IW   = (NUM_SCR > 1) ? $clog2(NUM_SCR) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              priv_i,
  input  logic              lock_i,
  output sel_e              sel_o,
  output logic [WIN_IW-1:0] win_idx_o,
  output logic [SCR_IW-1:0] scr_idx_o,
  output logic              wr_ok_o,
  output logic              blocked_o
);

  localparam int unsigned WIN_END = WIN_START + WIN_LEN - 1;
  localparam int unsigned SCR_END = SCR_BASE + NUM_SCR - 1;

  logic in_win, in_scr;

  assign in_win = (addr_i >= ADDR_W'(WIN_START)) && (addr_i <= ADDR_W'(WIN_END));
  assign in_scr = (addr_i >= ADDR_W'(SCR_BASE))  && (addr_i <= ADDR_W'(SCR_END));

  always_comb begin
    if (addr_i == ADDR_W'(LOCK_ADDR))      sel_o = SEL_LOCK;
    else if (addr_i == ADDR_W'(STAT_ADDR)) sel_o = SEL_STAT;
    else if (in_win)                       sel_o = SEL_WIN;
    else if (in_scr)                       sel_o = SEL_SCR;
    else                                   sel_o = SEL_NONE;
  end

  assign win_idx_o = WIN_IW'(addr_i - ADDR_W'(WIN_START));
  assign scr_idx_o = SCR_IW'(addr_i - ADDR_W'(SCR_BASE));

  // Window writes need privilege and a clear lock; control writes need privilege.
  always_comb begin
    wr_ok_o   = 1'b0;
    blocked_o = 1'b0;
    if (we_i) begin
      unique case (sel_o)
        SEL_LOCK, SEL_STAT: begin
          wr_ok_o   = priv_i;
          blocked_o = !priv_i;
        end
        SEL_WIN: begin
          wr_ok_o   = priv_i && !lock_i;
          blocked_o = !priv_i || lock_i;
        end
        SEL_SCR:  wr_ok_o = 1'b1;
        default:  wr_ok_o = 1'b0;
      endcase
    end
  end

  always_comb begin
    AST_GATE_EXCLUSIVE: assert (!(wr_ok_o && blocked_o)); // R5
  end

endmodule

// File: rtl/scal_lock_ctrl.sv
module scal_lock_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_we_i,
  input  logic lock_d_i,
  input  logic err_clr_i,
  input  logic blocked_i,
  output logic lock_o,
  output logic err_o,
  output logic viol_o
);

  logic lock_q, err_q, viol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        lock_q <= 1'b1;
    else if (lock_we_i) lock_q <= lock_d_i;
  end

  // Set wins over clear: a violation is never lost.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_q <= 1'b0;
    else if (blocked_i) err_q <= 1'b1;
    else if (err_clr_i) err_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) viol_q <= 1'b0;
    else         viol_q <= blocked_i;
  end

  assign lock_o = lock_q;
  assign err_o  = err_q;
  assign viol_o = viol_q;

  AST_VIOL_MARKS_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> err_o); // R5

  AST_LOCK_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_we_i |=> $stable(lock_o)); // R4

endmodule

// File: rtl/scal_win_regs.sv
module scal_win_regs #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_DOM  = 2,
  parameter int unsigned FREQ_RST = 'h10,
  parameter int unsigned VOLT_RST = 'h30,
  localparam int unsigned WIN_LEN = 2 * NUM_DOM,
  localparam int unsigned WIN_IW  = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [WIN_IW-1:0]           wr_idx_i,
  input  logic [DATA_W-1:0]           wdata_i,
  input  logic [WIN_IW-1:0]           rd_idx_i,
  output logic [DATA_W-1:0]           rd_data_o,
  output logic [NUM_DOM*DATA_W-1:0]   freq_o,
  output logic [NUM_DOM*DATA_W-1:0]   volt_o
);

  logic [DATA_W-1:0] freq_q [NUM_DOM];
  logic [DATA_W-1:0] volt_q [NUM_DOM];

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
    localparam logic [WIN_IW-1:0] F_IDX = WIN_IW'(2 * g);
    localparam logic [WIN_IW-1:0] V_IDX = WIN_IW'(2 * g + 1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          freq_q[g] <= DATA_W'(FREQ_RST);
      else if (we_i && wr_idx_i == F_IDX)   freq_q[g] <= wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          volt_q[g] <= DATA_W'(VOLT_RST);
      else if (we_i && wr_idx_i == V_IDX)   volt_q[g] <= wdata_i;
    end

    assign freq_o[g*DATA_W +: DATA_W] = freq_q[g];
    assign volt_o[g*DATA_W +: DATA_W] = volt_q[g];
  end

  always_comb begin
    rd_data_o = '0;
    for (int d = 0; d < NUM_DOM; d++) begin
      if (rd_idx_i == WIN_IW'(2 * d))     rd_data_o = freq_q[d];
      if (rd_idx_i == WIN_IW'(2 * d + 1)) rd_data_o = volt_q[d];
    end
  end

  AST_WIN_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(freq_o) && $stable(volt_o))); // R2

endmodule

// File: rtl/scal_scratch_regs.sv
module scal_scratch_regs #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned NUM_SCR = 2,
  localparam int unsigned SCR_IW = (NUM_SCR > 1) ? $clog2(NUM_SCR) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SCR_IW-1:0] wr_idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [SCR_IW-1:0] rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);

  logic [DATA_W-1:0] scr_q [NUM_SCR];

  for (genvar g = 0; g < NUM_SCR; g++) begin : g_scr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  scr_q[g] <= '0;
      else if (we_i && wr_idx_i == SCR_IW'(g))      scr_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int s = 0; s < NUM_SCR; s++) begin
      if (rd_idx_i == SCR_IW'(s)) rd_data_o = scr_q[s];
    end
  end

endmodule

// File: rtl/scal_ctrl_regs.sv
module scal_ctrl_regs
  import scal_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_DOM   = 2,
  parameter int unsigned NUM_SCR   = 2,
  parameter int unsigned LOCK_ADDR = 0,
  parameter int unsigned STAT_ADDR = 1,
  parameter int unsigned WIN_START = 4,
  parameter int unsigned SCR_BASE  = 8,
  parameter int unsigned FREQ_RST  = 'h10,
  parameter int unsigned VOLT_RST  = 'h30
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  input  logic                      we_i,
  input  logic                      re_i,
  input  logic                      priv_i,
  output logic [DATA_W-1:0]         rdata_o,
  output logic [NUM_DOM*DATA_W-1:0] freq_o,
  output logic [NUM_DOM*DATA_W-1:0] volt_o,
  output logic                      lock_o,
  output logic                      viol_o,
  output logic                      err_o
);

  localparam int unsigned WIN_LEN = 2 * NUM_DOM;
  localparam int unsigned WIN_IW  = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam int unsigned SCR_IW  = (NUM_SCR > 1) ? $clog2(NUM_SCR) : 1;

  sel_e              sel;
  logic [WIN_IW-1:0] win_idx;
  logic [SCR_IW-1:0] scr_idx;
  logic              wr_ok, blocked;
  logic              lock_we, err_clr, win_we, scr_we;
  logic [DATA_W-1:0] win_rd, scr_rd, rd_next, rdata_q;

  scal_access_gate #(
    .ADDR_W   (ADDR_W),
    .LOCK_ADDR(LOCK_ADDR),
    .STAT_ADDR(STAT_ADDR),
    .WIN_START(WIN_START),
    .WIN_LEN  (WIN_LEN),
    .SCR_BASE (SCR_BASE),
    .NUM_SCR  (NUM_SCR)
  ) i_gate (
    .addr_i   (addr_i),
    .we_i     (we_i),
    .priv_i   (priv_i),
    .lock_i   (lock_o),
    .sel_o    (sel),
    .win_idx_o(win_idx),
    .scr_idx_o(scr_idx),
    .wr_ok_o  (wr_ok),
    .blocked_o(blocked)
  );

  assign lock_we = wr_ok && (sel == SEL_LOCK);
  assign err_clr = wr_ok && (sel == SEL_STAT) && wdata_i[0];
  assign win_we  = wr_ok && (sel == SEL_WIN);
  assign scr_we  = wr_ok && (sel == SEL_SCR);

  scal_lock_ctrl i_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lock_we_i(lock_we),
    .lock_d_i (wdata_i[0]),
    .err_clr_i(err_clr),
    .blocked_i(blocked),
    .lock_o   (lock_o),
    .err_o    (err_o),
    .viol_o   (viol_o)
  );

  scal_win_regs #(
    .DATA_W  (DATA_W),
    .NUM_DOM (NUM_DOM),
    .FREQ_RST(FREQ_RST),
    .VOLT_RST(VOLT_RST)
  ) i_win (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (win_we),
    .wr_idx_i (win_idx),
    .wdata_i  (wdata_i),
    .rd_idx_i (win_idx),
    .rd_data_o(win_rd),
    .freq_o   (freq_o),
    .volt_o   (volt_o)
  );

  scal_scratch_regs #(
    .DATA_W (DATA_W),
    .NUM_SCR(NUM_SCR)
  ) i_scr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (scr_we),
    .wr_idx_i (scr_idx),
    .wdata_i  (wdata_i),
    .rd_idx_i (scr_idx),
    .rd_data_o(scr_rd)
  );

  always_comb begin
    unique case (sel)
      SEL_LOCK: rd_next = {{(DATA_W-1){1'b0}}, lock_o};
      SEL_STAT: rd_next = {{(DATA_W-1){1'b0}}, err_o};
      SEL_WIN:  rd_next = win_rd;
      SEL_SCR:  rd_next = scr_rd;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rd_next;
  end

  assign rdata_o = rdata_q;

  AST_UNPRIV_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !priv_i) |=> $stable(lock_o)); // R4

  AST_UNPRIV_WIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !priv_i) |=> ($stable(freq_o) && $stable(volt_o))); // R4

  AST_LOCKED_WIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && lock_o) |=> ($stable(freq_o) && $stable(volt_o))); // R3

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !(we_i && priv_i && addr_i == ADDR_W'(STAT_ADDR) && wdata_i[0]))
      |=> err_o); // R6

  AST_VIOL_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i) |=> !viol_o); // R5

  AST_READ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o)); // R7

  AST_SCR_NO_VIOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i >= ADDR_W'(SCR_BASE) && addr_i < ADDR_W'(SCR_BASE + NUM_SCR))
      |=> !viol_o); // R8

endmodule

// File: tb/test_scal_ctrl_regs.sv
module test_scal_ctrl_regs;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        we_i = 1'b0;
  logic        re_i = 1'b0;
  logic        priv_i = 1'b0;
  logic [7:0]  rdata_o;
  logic [15:0] freq_o, volt_o;
  logic        lock_o, viol_o, err_o;

  int n_chk = 0;
  int n_fail = 0;

  logic       lock_m, err_m;
  logic [7:0] freq_m [2];
  logic [7:0] volt_m [2];
  logic [7:0] scr_m  [2];

  always #10 clk_i = ~clk_i;

  scal_ctrl_regs i_scal_ctrl_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .we_i(we_i), .re_i(re_i), .priv_i(priv_i), .rdata_o(rdata_o),
    .freq_o(freq_o), .volt_o(volt_o), .lock_o(lock_o), .viol_o(viol_o),
    .err_o(err_o)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] model_read(int a);
    if (a == 0) return {7'd0, lock_m};
    if (a == 1) return {7'd0, err_m};
    if (a >= 4 && a <= 7) return a[0] ? volt_m[(a-4)/2] : freq_m[(a-4)/2];
    if (a == 8 || a == 9) return scr_m[a-8];
    return 8'h00;
  endfunction

  task automatic chk_outputs(string req);
    chk(req, "lock_o", 32'(lock_o), 32'(lock_m));
    chk(req, "err_o",  32'(err_o),  32'(err_m));
    chk(req, "freq_o", 32'(freq_o), 32'({freq_m[1], freq_m[0]}));
    chk(req, "volt_o", 32'(volt_o), 32'({volt_m[1], volt_m[0]}));
  endtask

  task automatic bus_write(int a, logic [7:0] d, logic p);
    logic blk;
    string req;
    blk = ((a == 0 || a == 1) && !p) || (a >= 4 && a <= 7 && (!p || lock_m));
    if (a >= 8 && a <= 9)            req = "R8";
    else if (a >= 4 && a <= 7 && !p) req = "R4";
    else if (a >= 4 && a <= 7 && lock_m) req = "R3";
    else if (a == 0)                 req = "R4";
    else if (a == 1)                 req = "R6";
    else                             req = "R2";
    @(negedge clk_i);
    addr_i = 4'(a); wdata_i = d; we_i = 1'b1; priv_i = p; re_i = 1'b0;
    @(negedge clk_i);
    we_i = 1'b0;
    if (blk) err_m = 1'b1;
    else if (a == 1 && d[0]) err_m = 1'b0;
    if (!blk) begin
      if (a == 0) lock_m = d[0];
      if (a >= 4 && a <= 7) begin
        if (a[0]) volt_m[(a-4)/2] = d; else freq_m[(a-4)/2] = d;
      end
      if (a == 8 || a == 9) scr_m[a-8] = d;
    end
    chk("R5", "viol_o", 32'(viol_o), 32'(blk));
    chk_outputs(req);
  endtask

  task automatic bus_read(int a, logic p);
    @(negedge clk_i);
    addr_i = 4'(a); re_i = 1'b1; priv_i = p; we_i = 1'b0;
    @(negedge clk_i);
    re_i = 1'b0;
    chk("R7", $sformatf("rdata addr %0d", a), 32'(rdata_o), 32'(model_read(a)));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    lock_m = 1'b1; err_m = 1'b0;
    for (int i = 0; i < 2; i++) begin
      freq_m[i] = 8'h10; volt_m[i] = 8'h30; scr_m[i] = 8'h00;
    end
    repeat (2) @(negedge clk_i);
    // R1 reset state
    chk_outputs("R1");
    chk("R1", "viol_o", 32'(viol_o), 32'd0);
    chk("R1", "rdata_o", 32'(rdata_o), 32'd0);
    rst_ni = 1'b1;
    for (int a = 0; a < 16; a++) bus_read(a, a[0]);

    // R2: output changes at the edge, not before
    bus_write(0, 8'h00, 1'b1);
    @(negedge clk_i);
    addr_i = 4'd6; wdata_i = 8'hA5; we_i = 1'b1; priv_i = 1'b1;
    #5;
    chk("R2", "freq_o before edge", 32'(freq_o), 32'({freq_m[1], freq_m[0]}));
    @(negedge clk_i);
    we_i = 1'b0;
    freq_m[1] = 8'hA5;
    chk("R2", "freq_o after edge", 32'(freq_o), 32'({freq_m[1], freq_m[0]}));

    // R7: rdata holds while no read is issued
    bus_read(6, 1'b0);
    bus_write(8, 8'h3C, 1'b0);
    chk("R7", "rdata hold", 32'(rdata_o), 32'h0A5);
    bus_read(8, 1'b0);

    // R6 directed
    bus_write(4, 8'h77, 1'b0);
    bus_write(1, 8'h01, 1'b0);
    chk("R6", "err kept after unpriv clear", 32'(err_o), 32'd1);
    bus_write(1, 8'h00, 1'b1);
    chk("R6", "err kept after clear with bit0=0", 32'(err_o), 32'd1);
    bus_read(1, 1'b0);
    bus_write(1, 8'h01, 1'b1);
    chk("R6", "err cleared", 32'(err_o), 32'd0);

    // Sweep: lock state x privilege x address
    for (int l = 0; l < 2; l++) begin
      for (int p = 0; p < 2; p++) begin
        for (int a = 0; a < 16; a++) begin
          bus_write(0, 8'(l), 1'b1);
          bus_write(a, 8'(a * 29 + p * 83 + l * 7 + 1), p[0]);
          for (int r = 0; r < 16; r++) bus_read(r, r[1]);
          bus_write(1, 8'h01, 1'b1);
        end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule